// File: doc/BRIEF.md
# Serial Boot-Mode Configuration Loader

At power-up this block assembles a wide configuration word from a one-pin serial stream and holds it for the rest of the chip. It produces the serial strobe itself: the system clock is divided by a fixed ratio and sent out as a mode clock. A new load begins whenever the power-good input rises. Bits are captured on the rising edge of the mode clock, least significant bit first. After the last bit the block raises a done flag and parks the mode clock low.

Only one field of the word is decoded here: the two-bit output-drive timing selector, which gives a "fast" and a "slow" flag. If power-good falls in the middle of a load, the partial word is thrown away. A warm reset leaves the stored word alone. Warm reset only gates the run permission, which goes high once the word is complete and warm reset is released. Cold reset is active low and synchronous, and it clears everything.

Top module: `boot_mode_loader`

## Requirements
- R1: While `cold_rst_n` is sampled low at a clock edge, all of these are 0 after that edge: `mode_word`, `load_done`, `mode_clk`, `drive_fast`, `drive_slow` and `core_run`.
- R2: During a load, `mode_clk` is a square wave with a period of DIV system clocks and a high time of DIV/2. Its first rising edge comes DIV/2 clocks after the start edge.
- R3: A load starts at the first clock edge where `pwr_ok` is high and was low at the previous edge (or on the first edge after cold reset). This also applies when a word is already held. The start clears `mode_word` and `load_done` at that edge.
- R4: `mode_din` is sampled at the clock edge where `mode_clk` rises. Each new bit enters at the top of a right-shifting register, so the first bit ends up in bit 0. After WORD_W captures, `mode_word` equals the stream.
- R5: `load_done` rises at the edge that captures the final bit. From the next edge on, `mode_clk` stays low for as long as no load is running.
- R6: If `pwr_ok` is low during a load, the load aborts at that edge. `mode_word` becomes 0, `load_done` stays 0 and `mode_clk` becomes 0, and the block waits for a new rising edge of `pwr_ok`.
- R7: Once `load_done` is high, `mode_word` and `load_done` do not change, including when `pwr_ok` falls. Only a new rising edge of `pwr_ok` (R3) or a cold reset changes them.
- R8: The drive field is `mode_word[DRIVE_LSB+1:DRIVE_LSB]`. The value 2'b10 sets `drive_fast`, 2'b01 sets `drive_slow`, and any other value sets neither. Both flags are registered from the done word one clock after `load_done` rises, and both are 0 while `load_done` is 0.
- R9: `core_run` is the registered value of `load_done` AND `warm_rst_n`. A low `warm_rst_n` changes neither `mode_word` nor `load_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| cold_rst_n | input | 1 | Cold reset, active low, synchronous |
| warm_rst_n | input | 1 | Warm reset, active low, synchronous; gates run permission only |
| pwr_ok | input | 1 | Power-good; its rising edge starts a load, low during a load aborts it |
| mode_din | input | 1 | Serial configuration data |
| mode_clk | output | 1 | Generated serial strobe, clk / DIV |
| mode_word | output | WORD_W | Assembled configuration word |
| load_done | output | 1 | Word complete |
| drive_fast | output | 1 | Drive field selects the fastest output timing |
| drive_slow | output | 1 | Drive field selects the slowest output timing |
| core_run | output | 1 | Permission to release the core from reset |

## Verification
The bench builds the loader with DIV=8 and WORD_W=24, and keeps DRIVE_LSB=14 so that the drive field sits in the same place as in the default build. With these values a complete load takes about 200 clocks. That leaves room for several random words and for directed words that cover every drive code. It also covers an abort in mid-stream, a reload over a held word, a warm reset while a word is held, and an exact count of the mode clock's phase lengths.

// File: rtl/boot_mode_pkg.sv
package boot_mode_pkg;
  typedef enum logic [1:0] {
    BL_IDLE = 2'd0,
    BL_LOAD = 2'd1,
    BL_DONE = 2'd2
  } bl_state_e;

  localparam logic [1:0] DRV_FAST_CODE = 2'b10;
  localparam logic [1:0] DRV_SLOW_CODE = 2'b01;
endpackage

// File: rtl/boot_clk_div.sv
module boot_clk_div #(
  parameter int DIV = 256
) (
  input  logic clk,
  input  logic clr,
  input  logic en,
  output logic mode_clk,
  output logic sample
);
  localparam int CNT_W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int HALF  = DIV / 2;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);
  localparam logic [CNT_W-1:0] RISE = CNT_W'(HALF);
  localparam logic [CNT_W-1:0] PRE  = CNT_W'(HALF - 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_nxt;

  assign cnt_nxt = (cnt == LAST) ? '0 : cnt + 1'b1;
  assign sample  = en && (cnt == PRE);

  always_ff @(posedge clk) begin
    if (clr || !en) begin
      cnt      <= '0;
      mode_clk <= 1'b0;
    end else begin
      cnt      <= cnt_nxt;
      mode_clk <= (cnt_nxt >= RISE);
    end
  end

  // R5
  clk_parked_chk: assert property (@(posedge clk) disable iff (clr)
    !en |=> !mode_clk);
endmodule

// File: rtl/boot_shift_reg.sv
module boot_shift_reg #(
  parameter int WORD_W = 256
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              shift,
  input  logic              din,
  output logic [WORD_W-1:0] word,
  output logic              last_bit
);
  localparam int BIT_W = $clog2(WORD_W + 1);
  localparam logic [BIT_W-1:0] FINAL = BIT_W'(WORD_W - 1);

  logic [BIT_W-1:0] count;

  assign last_bit = (count == FINAL);

  always_ff @(posedge clk) begin
    if (clr) begin
      word  <= '0;
      count <= '0;
    end else if (shift) begin
      word  <= {din, word[WORD_W-1:1]};
      count <= count + 1'b1;
    end
  end

  // R4
  clear_state_chk: assert property (@(posedge clk)
    clr |=> (word == '0) && (count == '0));
endmodule

// File: rtl/boot_drive_dec.sv
module boot_drive_dec #(
  parameter int WORD_W    = 256,
  parameter int DRIVE_LSB = 14
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              done,
  input  logic [WORD_W-1:0] word,
  output logic              drive_fast,
  output logic              drive_slow
);
  import boot_mode_pkg::*;

  logic [1:0] field;
  assign field = word[DRIVE_LSB +: 2];

  always_ff @(posedge clk) begin
    if (clr) begin
      drive_fast <= 1'b0;
      drive_slow <= 1'b0;
    end else begin
      drive_fast <= done && (field == DRV_FAST_CODE);
      drive_slow <= done && (field == DRV_SLOW_CODE);
    end
  end

  // R8
  drive_idle_chk: assert property (@(posedge clk) disable iff (clr)
    !done |=> !drive_fast && !drive_slow);
endmodule

// File: rtl/boot_mode_loader.sv
module boot_mode_loader #(
  parameter int DIV       = 256,
  parameter int WORD_W    = 256,
  parameter int DRIVE_LSB = 14
) (
  input  logic              clk,
  input  logic              cold_rst_n,
  input  logic              warm_rst_n,
  input  logic              pwr_ok,
  input  logic              mode_din,
  output logic              mode_clk,
  output logic [WORD_W-1:0] mode_word,
  output logic              load_done,
  output logic              drive_fast,
  output logic              drive_slow,
  output logic              core_run
);
  import boot_mode_pkg::*;

  bl_state_e state;
  logic pwr_q, done_q, run_q;
  logic pwr_rise, loading, abort, start, sample, shift_en, last_bit, finish;
  logic clr;

  assign clr      = !cold_rst_n;
  assign pwr_rise = pwr_ok && !pwr_q;
  assign loading  = (state == BL_LOAD);
  assign abort    = loading && !pwr_ok;
  assign start    = !loading && pwr_rise;
  assign shift_en = loading && pwr_ok && sample;
  assign finish   = shift_en && last_bit;

  always_ff @(posedge clk) begin
    if (clr) begin
      state  <= BL_IDLE;
      pwr_q  <= 1'b0;
      done_q <= 1'b0;
      run_q  <= 1'b0;
    end else begin
      pwr_q <= pwr_ok;
      run_q <= done_q && warm_rst_n;
      if (start) begin
        state  <= BL_LOAD;
        done_q <= 1'b0;
      end else if (abort) begin
        state <= BL_IDLE;
      end else if (finish) begin
        state  <= BL_DONE;
        done_q <= 1'b1;
      end
    end
  end

  boot_clk_div #(.DIV(DIV)) u_div (
    .clk(clk), .clr(clr), .en(loading && pwr_ok),
    .mode_clk(mode_clk), .sample(sample)
  );

  boot_shift_reg #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .clr(clr || start || abort), .shift(shift_en),
    .din(mode_din), .word(mode_word), .last_bit(last_bit)
  );

  boot_drive_dec #(.WORD_W(WORD_W), .DRIVE_LSB(DRIVE_LSB)) u_dec (
    .clk(clk), .clr(clr), .done(done_q), .word(mode_word),
    .drive_fast(drive_fast), .drive_slow(drive_slow)
  );

  assign load_done = done_q;
  assign core_run  = run_q;

  // R6
  abort_clear_chk: assert property (@(posedge clk) disable iff (clr)
    abort |=> (mode_word == '0) && !load_done && !mode_clk);

  // R7
  hold_word_chk: assert property (@(posedge clk) disable iff (clr)
    load_done && !pwr_rise |=> load_done && $stable(mode_word));

  // R9
  run_gate_chk: assert property (@(posedge clk) disable iff (clr)
    !load_done |=> !core_run);
endmodule

// File: tb/sim_boot_mode_loader.sv
module sim_boot_mode_loader;
  localparam int B_DIV = 8;
  localparam int B_W   = 24;
  localparam int B_LSB = 14;

  logic clk = 1'b0;
  logic cold_rst_n = 1'b0, warm_rst_n = 1'b1, pwr_ok = 1'b0, mode_din = 1'b0;
  logic mode_clk, load_done, drive_fast, drive_slow, core_run;
  logic [B_W-1:0] mode_word;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  boot_mode_loader #(.DIV(B_DIV), .WORD_W(B_W), .DRIVE_LSB(B_LSB)) u0 (
    .clk(clk), .cold_rst_n(cold_rst_n), .warm_rst_n(warm_rst_n),
    .pwr_ok(pwr_ok), .mode_din(mode_din), .mode_clk(mode_clk),
    .mode_word(mode_word), .load_done(load_done), .drive_fast(drive_fast),
    .drive_slow(drive_slow), .core_run(core_run)
  );

  function automatic logic exp_fast(input logic [B_W-1:0] w);
    return w[B_LSB +: 2] == 2'b10;
  endfunction
  function automatic logic exp_slow(input logic [B_W-1:0] w);
    return w[B_LSB +: 2] == 2'b01;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_lvl(input logic lvl);
    do @(negedge clk); while (mode_clk !== lvl);
  endtask

  task automatic load(input logic [B_W-1:0] w, input int nbits);
    pwr_ok = 1'b0;
    @(negedge clk); @(negedge clk);
    mode_din = w[0];
    pwr_ok = 1'b1;
    for (int i = 0; i < nbits; i++) begin
      wait_lvl(1'b1);
      wait_lvl(1'b0);
      if (i + 1 < B_W) mode_din = w[i + 1];
    end
  endtask

  task automatic full_check(input logic [B_W-1:0] w, input string tag);
    @(negedge clk);
    chk(mode_word === w, {tag, " R4 word"}, 64'(mode_word), 64'(w));
    chk(load_done === 1'b1, {tag, " R5 done"}, 64'(load_done), 64'd1);
    chk(drive_fast === exp_fast(w), {tag, " R8 fast"}, 64'(drive_fast), 64'(exp_fast(w)));
    chk(drive_slow === exp_slow(w), {tag, " R8 slow"}, 64'(drive_slow), 64'(exp_slow(w)));
    chk(core_run === 1'b1, {tag, " R9 run"}, 64'(core_run), 64'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [B_W-1:0] w, held;
    int n;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({mode_word, load_done, mode_clk, drive_fast, drive_slow, core_run} === '0,
        "R1 reset", 64'(mode_word), 64'd0);
    cold_rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(mode_clk === 1'b0, "R5 idle clk", 64'(mode_clk), 64'd0);

    // R2 mode clock shape, then R6 abort
    mode_din = 1'b1;
    pwr_ok = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (mode_clk !== 1'b1);
    chk(n == B_DIV / 2 + 1, "R2 first rise", 64'(n), 64'(B_DIV / 2 + 1));
    chk(mode_word[B_W-1] === 1'b1, "R4 msb entry", 64'(mode_word[B_W-1]), 64'd1);
    n = 0;
    do begin @(negedge clk); n++; end while (mode_clk === 1'b1);
    chk(n == B_DIV / 2, "R2 high time", 64'(n), 64'(B_DIV / 2));
    n = 0;
    do begin @(negedge clk); n++; end while (mode_clk !== 1'b1);
    chk(n == B_DIV / 2, "R2 low time", 64'(n), 64'(B_DIV / 2));
    pwr_ok = 1'b0;
    @(negedge clk);
    chk(mode_word === '0, "R6 abort word", 64'(mode_word), 64'd0);
    chk({load_done, mode_clk} === 2'b00, "R6 abort flags", 64'({load_done, mode_clk}), 64'd0);

    // directed drive codes
    w = 24'h00_8000 | 24'h12_3456; w[B_LSB +: 2] = 2'b10;
    load(w, B_W); full_check(w, "dir10");
    n = 0;
    repeat (3 * B_DIV) begin @(negedge clk); if (mode_clk !== 1'b0) n++; end
    chk(n == 0, "R5 parked clk", 64'(n), 64'd0);
    w = 24'hA5_5A3C; w[B_LSB +: 2] = 2'b01; load(w, B_W); full_check(w, "dir01");
    w = 24'hFF_FFFF; load(w, B_W); full_check(w, "dir11");
    w = 24'h00_0001; load(w, B_W); full_check(w, "dir00");

    // random words
    for (int k = 0; k < 5; k++) begin
      w = B_W'($urandom);
      load(w, B_W); full_check(w, "rand");
    end

    // R7 power-good fall after done is ignored
    held = mode_word;
    pwr_ok = 1'b0;
    repeat (2 * B_DIV) @(negedge clk);
    chk(mode_word === held, "R7 hold word", 64'(mode_word), 64'(held));
    chk(load_done === 1'b1, "R7 hold done", 64'(load_done), 64'd1);

    // R9 warm reset
    warm_rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(core_run === 1'b0, "R9 warm run", 64'(core_run), 64'd0);
    chk(mode_word === held && load_done === 1'b1, "R9 warm keeps word",
        64'(mode_word), 64'(held));
    warm_rst_n = 1'b1;
    @(negedge clk);
    chk(core_run === 1'b1, "R9 warm release", 64'(core_run), 64'd1);

    // R3 new rising edge clears a held word
    pwr_ok = 1'b1;
    @(negedge clk);
    chk(mode_word === '0 && load_done === 1'b0, "R3 restart clears",
        64'(mode_word), 64'd0);
    @(negedge clk);
    chk(core_run === 1'b0, "R9 run drops", 64'(core_run), 64'd0);

    // R6 abort in mid-stream, then R3 reload
    w = 24'h7E_81C3;
    load(w, 10);
    pwr_ok = 1'b0;
    @(negedge clk);
    chk(mode_word === '0 && load_done === 1'b0, "R6 mid abort", 64'(mode_word), 64'd0);
    repeat (2 * B_DIV) @(negedge clk);
    chk(mode_clk === 1'b0 && load_done === 1'b0, "R6 stays idle", 64'(mode_clk), 64'd0);
    w = 24'h3C_4000; load(w, B_W); full_check(w, "reload R3");

    // R1 cold reset after done
    cold_rst_n = 1'b0;
    @(negedge clk);
    chk({mode_word, load_done, drive_fast, drive_slow, core_run} === '0,
        "R1 cold after done", 64'(mode_word), 64'd0);
    cold_rst_n = 1'b1;
    @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule